// File: doc/BRIEF.md
# PHY Vendor-Register Access Sequencer

This block is the master side of a narrow indirect path to the 8-bit vendor-control registers inside a USB 2.0 PHY. A single command (read, write or page select) is turned into a short, strictly ordered conversation over a 32-bit access word. Each address goes out as two 4-bit control phases, low nibble first, and each phase is gated by polling the PHY's busy flag with a bounded timeout. Write data is staged beforehand in a separate status-out word at the byte lane that belongs to this port.

Reads shift the register address down by 0x20 before splitting it into nibbles, and return the low byte of the PHY status word once the last busy poll has passed. A page select is a write of a fixed code to the page register at address 0xF4. Poll interval and timeout are clock-cycle counts set by parameters, so short values can be used for simulation and the real microsecond values in silicon.

Top module: `phyacc_master`

## Requirements
- R1: After reset cmd_done, cmd_err, vstat_wr, cmd_rdata and acc_word are all zero.
- R2: A write (cmd_op=1) or valid page select pulses vstat_wr for one cycle before the first request, with vstat_word holding the data byte at bits [8*PORT_IDX+7:8*PORT_IDX] and zero elsewhere.
- R3: Each command that reaches the PHY issues exactly two requests: first with bits [11:8] of acc_word holding address bits [3:0], then with them holding address bits [7:4].
- R4: A read (cmd_op=0) sends the address minus 0x20, modulo 256, split as in R3; writes send the address unchanged.
- R5: A successful read returns on cmd_rdata, in the done cycle, bits [7:0] of phy_status as sampled after the final busy poll.
- R6: No request is issued while phy_status bit 23 (busy) is high; every request is preceded by a poll that saw busy low.
- R7: The request strobe is acc_word bit 25, held for exactly one cycle per phase; acc_word is zero in every other cycle and carries no bits outside 25 and [11:8].
- R8: If busy stays high for TIMEOUT_CYC cycles of polling, the command ends with cmd_done and cmd_err, and no further request is issued.
- R9: A page select (cmd_op=2) with page number cmd_wdata 0, 1, 2 writes code 0x9B, 0xBB, 0xDB to address 0xF4; any other page number, or cmd_op=3, ends at once with cmd_err and no PHY traffic.
- R10: cmd_done is a one-cycle pulse per command, and cmd_err is high only together with cmd_done.
- R11: cmd_start is ignored while a command is in progress.
- R12: Busy is re-examined every POLL_CYC cycles, so a request follows busy falling within POLL_CYC plus a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a command (taken only when idle) |
| cmd_op | input | 2 | 0 read, 1 write, 2 page select, 3 reserved |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data, or page number for a page select |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Error, valid with cmd_done |
| cmd_rdata | output | 8 | Read result |
| acc_word | output | 32 | Access word: request strobe and control nibble |
| phy_status | input | 32 | PHY status: busy flag and read byte |
| vstat_word | output | 32 | Status-out word holding staged write data |
| vstat_wr | output | 1 | One-cycle strobe loading vstat_word |

## Verification
A wrong sequencer state shows at acc_word within one phase: a swapped, repeated or missing nibble is visible on the next request, and the bench compares every nibble of every address in full read and write sweeps. A poll that leaves its wait too early shows as a request while busy is high, caught on that very edge; one that never gives up shows as a done arriving outside the timeout window. A stale address or data register shows in the nibble pair, the staged byte or the returned read byte of the same command.

// File: rtl/phyacc_pkg.sv
// Shared constants and types for the PHY vendor-register access sequencer.
// Assumes a 32-bit access word with fixed strobe/busy/nibble positions.
package phyacc_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int REQ_BIT  = 25;
    localparam int BUSY_BIT = 23;
    localparam int NIB_LSB  = 8;
    localparam logic [7:0] RD_OFS   = 8'h20;
    localparam logic [7:0] PAGE_REG = 8'hF4;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PAGE  = 2'd2,
        OP_RSV   = 2'd3
    } op_e;

    // Returns {valid, code} for a page number.
    function automatic logic [8:0] page_code(input logic [7:0] pg);
        case (pg)
            8'd0:    page_code = {1'b1, 8'h9B};
            8'd1:    page_code = {1'b1, 8'hBB};
            8'd2:    page_code = {1'b1, 8'hDB};
            default: page_code = {1'b0, 8'h00};
        endcase
    endfunction
endpackage

// File: rtl/phyacc_poll.sv
// Busy poller: after a go pulse, samples busy once every POLL_CYC cycles and
// reports fin when busy is low, or fin+tout once TIMEOUT_CYC cycles of
// polling have elapsed with busy still high. Assumes go arrives only idle.
module phyacc_poll #(
    parameter int POLL_CYC    = 4,
    parameter int TIMEOUT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic busy,
    output logic fin,
    output logic tout
);
    localparam int IW = $clog2(POLL_CYC + 1);
    localparam int EW = $clog2(TIMEOUT_CYC + 1) + 1;
    localparam logic [IW-1:0] IV_RLD = IW'(POLL_CYC - 1);
    localparam logic [EW-1:0] EL_LIM = EW'(TIMEOUT_CYC);

    logic          active;
    logic [IW-1:0] ivl;
    logic [EW-1:0] el;

    // Interval and elapsed counters, busy sampling and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ivl    <= '0;
            el     <= '0;
            fin    <= 1'b0;
            tout   <= 1'b0;
        end else begin
            fin  <= 1'b0;
            tout <= 1'b0;
            if (go) begin
                active <= 1'b1;
                ivl    <= '0;
                el     <= '0;
            end else if (active) begin
                if (el < EL_LIM) el <= el + 1'b1;
                if (ivl == '0) begin
                    if (!busy) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else if (el >= EL_LIM) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                        tout   <= 1'b1;
                    end else begin
                        ivl <= IV_RLD;
                    end
                end else begin
                    ivl <= ivl - 1'b1;
                end
            end
        end
    end

    // R8
    tout_with_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout |-> fin);
    // R6
    fin_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(active));
endmodule

// File: rtl/phyacc_seq.sv
// Command sequencer: accepts one command when idle, stages write data,
// then runs wait / low nibble / wait / high nibble / wait on the access word.
// Assumes phyacc_poll reports each wait's outcome through fin/tout.
module phyacc_seq
    import phyacc_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [7:0]        cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic [7:0]        cmd_rdata,
    output logic [WORD_W-1:0] acc_word,
    input  logic [WORD_W-1:0] phy_status,
    output logic [WORD_W-1:0] vstat_word,
    output logic              vstat_wr,
    output logic              poll_go,
    input  logic              poll_fin,
    input  logic              poll_tout
);
    localparam int LANE_SH = BYTE_W * PORT_IDX;

    typedef enum logic [2:0] {S_IDLE, S_W0, S_NLO, S_W1, S_NHI, S_W2} st_e;

    st_e        state;
    logic       is_rd;
    logic [7:0] adr_q;
    logic [8:0] pg;

    assign pg = page_code(cmd_wdata);

    // Access word: strobe plus the current nibble, only in the two send states.
    always_comb begin
        acc_word = '0;
        if (state == S_NLO) begin
            acc_word[REQ_BIT] = 1'b1;
            acc_word[NIB_LSB +: 4] = adr_q[3:0];
        end else if (state == S_NHI) begin
            acc_word[REQ_BIT] = 1'b1;
            acc_word[NIB_LSB +: 4] = adr_q[7:4];
        end
    end

    // Main sequence: command intake, phase stepping, completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            is_rd      <= 1'b0;
            adr_q      <= '0;
            cmd_done   <= 1'b0;
            cmd_err    <= 1'b0;
            cmd_rdata  <= '0;
            vstat_word <= '0;
            vstat_wr   <= 1'b0;
            poll_go    <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            cmd_err  <= 1'b0;
            vstat_wr <= 1'b0;
            poll_go  <= 1'b0;
            case (state)
                S_IDLE: if (cmd_start) begin
                    case (op_e'(cmd_op))
                        OP_READ: begin
                            is_rd   <= 1'b1;
                            adr_q   <= cmd_addr - RD_OFS;
                            poll_go <= 1'b1;
                            state   <= S_W0;
                        end
                        OP_WRITE: begin
                            is_rd      <= 1'b0;
                            adr_q      <= cmd_addr;
                            vstat_word <= WORD_W'(cmd_wdata) << LANE_SH;
                            vstat_wr   <= 1'b1;
                            poll_go    <= 1'b1;
                            state      <= S_W0;
                        end
                        OP_PAGE: begin
                            if (pg[8]) begin
                                is_rd      <= 1'b0;
                                adr_q      <= PAGE_REG;
                                vstat_word <= WORD_W'(pg[7:0]) << LANE_SH;
                                vstat_wr   <= 1'b1;
                                poll_go    <= 1'b1;
                                state      <= S_W0;
                            end else begin
                                cmd_done <= 1'b1;
                                cmd_err  <= 1'b1;
                            end
                        end
                        default: begin
                            cmd_done <= 1'b1;
                            cmd_err  <= 1'b1;
                        end
                    endcase
                end
                S_W0, S_W1: if (poll_fin) begin
                    if (poll_tout) begin
                        cmd_done <= 1'b1;
                        cmd_err  <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        state <= (state == S_W0) ? S_NLO : S_NHI;
                    end
                end
                S_NLO: begin
                    poll_go <= 1'b1;
                    state   <= S_W1;
                end
                S_NHI: begin
                    poll_go <= 1'b1;
                    state   <= S_W2;
                end
                S_W2: if (poll_fin) begin
                    cmd_done <= 1'b1;
                    cmd_err  <= poll_tout;
                    if (!poll_tout && is_rd) cmd_rdata <= phy_status[BYTE_W-1:0];
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6
    req_after_clear_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_word[REQ_BIT] |-> $past(poll_fin && !poll_tout));
    // R7
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_word[REQ_BIT] |=> !acc_word[REQ_BIT]);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);
    // R2
    stage_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vstat_wr |-> !acc_word[REQ_BIT]);
endmodule

// File: rtl/phyacc_master.sv
// Top of the PHY vendor-register access sequencer: binds the command
// sequencer to the busy poller. Assumes one PHY port at lane PORT_IDX.
module phyacc_master
    import phyacc_pkg::*;
#(
    parameter int PORT_IDX    = 0,
    parameter int POLL_CYC    = 20000,
    parameter int TIMEOUT_CYC = 10000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_addr,
    input  logic [7:0]  cmd_wdata,
    output logic        cmd_done,
    output logic        cmd_err,
    output logic [7:0]  cmd_rdata,
    output logic [31:0] acc_word,
    input  logic [31:0] phy_status,
    output logic [31:0] vstat_word,
    output logic        vstat_wr
);
    logic poll_go;
    logic poll_fin;
    logic poll_tout;

    phyacc_seq #(.PORT_IDX(PORT_IDX)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cmd_done   (cmd_done),
        .cmd_err    (cmd_err),
        .cmd_rdata  (cmd_rdata),
        .acc_word   (acc_word),
        .phy_status (phy_status),
        .vstat_word (vstat_word),
        .vstat_wr   (vstat_wr),
        .poll_go    (poll_go),
        .poll_fin   (poll_fin),
        .poll_tout  (poll_tout)
    );

    phyacc_poll #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (poll_go),
        .busy  (phy_status[BUSY_BIT]),
        .fin   (poll_fin),
        .tout  (poll_tout)
    );
endmodule

// File: tb/phyacc_master_bench.sv
module phyacc_master_bench;
    localparam int PI = 2;
    localparam int PC = 4;
    localparam int TC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [7:0]  cmd_wdata = 8'd0;
    logic        cmd_done, cmd_err;
    logic [7:0]  cmd_rdata;
    logic [31:0] acc_word, phy_status, vstat_word;
    logic        vstat_wr;

    always #2.5 clk = ~clk;

    phyacc_master #(.PORT_IDX(PI), .POLL_CYC(PC), .TIMEOUT_CYC(TC)) u_phyacc_master (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .acc_word(acc_word),
        .phy_status(phy_status), .vstat_word(vstat_word), .vstat_wr(vstat_wr)
    );

    // PHY responder model and protocol monitors
    int          lat = 0;
    logic        stuck_pre = 1'b0;
    logic        stuck_arm = 1'b0;
    logic        mid_flag = 1'b0;
    int          bcnt = 0;
    logic [7:0]  rsp_byte = 8'h00;
    logic [3:0]  last_nib = 4'h0;
    logic [3:0]  nibs [0:4095];
    int          req_cyc [0:4095];
    int          nib_cnt = 0, viol = 0, bad_word = 0, ewd = 0, dcnt = 0, vcnt = 0;
    logic [31:0] vst_last = 0;
    logic        prev_req = 1'b0;
    int          cyc = 0;
    logic        busy;

    assign busy = stuck_pre | mid_flag | (bcnt != 0);
    assign phy_status = (32'(busy) << 23) | 32'(rsp_byte);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bcnt != 0) bcnt <= bcnt - 1;
        if (!stuck_arm) mid_flag <= 1'b0;
        prev_req <= acc_word[25];
        if (acc_word != 0 && (!acc_word[25] || (acc_word & ~32'h0200_0F00) != 0)) bad_word <= bad_word + 1;
        if (acc_word[25] && prev_req) bad_word <= bad_word + 1;
        if (cmd_err && !cmd_done) ewd <= ewd + 1;
        if (cmd_done) dcnt <= dcnt + 1;
        if (vstat_wr) begin vcnt <= vcnt + 1; vst_last <= vstat_word; end
        if (acc_word[25]) begin
            if (busy) viol <= viol + 1;
            nibs[nib_cnt]    <= acc_word[11:8];
            req_cyc[nib_cnt] <= cyc;
            nib_cnt  <= nib_cnt + 1;
            last_nib <= acc_word[11:8];
            rsp_byte <= {acc_word[11:8], last_nib} ^ 8'h5A;
            bcnt     <= lat;
            if (stuck_arm) mid_flag <= 1'b1;
        end
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    int         o_dt;
    logic       o_err;
    logic [7:0] o_rd;
    int         b_nib, b_vc, b_dc;

    task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
        int t0;
        bit got;
        b_nib = nib_cnt; b_vc = vcnt; b_dc = dcnt;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        cmd_start = 1'b0;
        got = 0;
        if (cmd_done) begin got = 1; o_err = cmd_err; o_rd = cmd_rdata; o_dt = cyc - t0; end
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (cmd_done) begin got = 1; o_err = cmd_err; o_rd = cmd_rdata; o_dt = cyc - t0; end
        end
        if (!got) begin o_err = 1'bx; o_dt = -1; end
        chk("R10 done seen", 32'(got), 1);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] codes [0:2];
        codes[0] = 9'h09B; codes[1] = 9'h0BB; codes[2] = 9'h0DB;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(cmd_done), 0);
        chk("R1 err", 32'(cmd_err), 0);
        chk("R1 acc_word", acc_word, 0);
        chk("R1 vstat_wr", 32'(vstat_wr), 0);
        chk("R1 rdata", 32'(cmd_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 write sweep over every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d;
            d = 8'(a * 7 + 3);
            lat = a % 4;
            run_op(2'd1, 8'(a), d);
            chk("R8 write no err", 32'(o_err), 0);
            chk("R3 two requests", 32'(nib_cnt - b_nib), 2);
            chk("R3 low nibble first", 32'(nibs[b_nib]), 32'(a & 15));
            chk("R3 high nibble second", 32'(nibs[b_nib+1]), 32'(a >> 4));
            chk("R2 staged once", 32'(vcnt - b_vc), 1);
            chk("R2 staged lane", vst_last, 32'(d) << (8 * PI));
            chk("R10 one done", 32'(dcnt - b_dc), 1);
        end

        // R4 R5 read sweep over every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] ea;
            ea = 8'(a - 32);
            lat = (a >> 2) % 4;
            run_op(2'd0, 8'(a), 8'h00);
            chk("R8 read no err", 32'(o_err), 0);
            chk("R4 low nibble", 32'(nibs[b_nib]), 32'(ea[3:0]));
            chk("R4 high nibble", 32'(nibs[b_nib+1]), 32'(ea[7:4]));
            chk("R5 read byte", 32'(o_rd), 32'(ea ^ 8'h5A));
            chk("R4 read no staging", 32'(vcnt - b_vc), 0);
        end

        // R9 valid pages
        lat = 2;
        for (int p = 0; p < 3; p++) begin
            run_op(2'd2, 8'h00, 8'(p));
            chk("R9 page no err", 32'(o_err), 0);
            chk("R9 page low nibble", 32'(nibs[b_nib]), 4);
            chk("R9 page high nibble", 32'(nibs[b_nib+1]), 15);
            chk("R9 page code", vst_last, 32'(codes[p][7:0]) << (8 * PI));
        end
        // R9 invalid pages and reserved op
        for (int k = 0; k < 3; k++) begin
            logic [1:0] op;
            logic [7:0] pgn;
            op  = (k == 2) ? 2'd3 : 2'd2;
            pgn = (k == 0) ? 8'd3 : 8'hFF;
            run_op(op, 8'h10, pgn);
            chk("R9 reject err", 32'(o_err), 1);
            chk("R9 reject fast", 32'(o_dt <= 3), 1);
            chk("R9 reject no request", 32'(nib_cnt - b_nib), 0);
            chk("R9 reject no staging", 32'(vcnt - b_vc), 0);
        end

        // R12 long busy: gap between the two requests
        lat = 13;
        run_op(2'd1, 8'hA5, 8'h11);
        chk("R12 gap lower", 32'(req_cyc[b_nib+1] - req_cyc[b_nib] >= 13), 1);
        chk("R12 gap upper", 32'(req_cyc[b_nib+1] - req_cyc[b_nib] <= 13 + PC + 5), 1);
        lat = 1;

        // R8 busy stuck before the first phase
        stuck_pre = 1'b1;
        run_op(2'd1, 8'h3C, 8'h77);
        chk("R8 timeout err", 32'(o_err), 1);
        chk("R8 no request", 32'(nib_cnt - b_nib), 0);
        chk("R8 window low", 32'(o_dt >= TC), 1);
        chk("R8 window high", 32'(o_dt <= TC + PC + 8), 1);
        stuck_pre = 1'b0;
        // R8 busy stuck after the low nibble
        stuck_arm = 1'b1;
        run_op(2'd0, 8'h66, 8'h00);
        chk("R8 mid timeout err", 32'(o_err), 1);
        chk("R8 mid single request", 32'(nib_cnt - b_nib), 1);
        stuck_arm = 1'b0;
        repeat (2) @(negedge clk);

        // R11 second start during a command
        lat = 3;
        b_nib = nib_cnt; b_vc = vcnt; b_dc = dcnt;
        @(negedge clk);
        cmd_op = 2'd1; cmd_addr = 8'h12; cmd_wdata = 8'h44; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (2) @(negedge clk);
        cmd_addr = 8'h34; cmd_wdata = 8'h99; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (80) @(negedge clk);
        chk("R11 one done", 32'(dcnt - b_dc), 1);
        chk("R11 two requests", 32'(nib_cnt - b_nib), 2);
        chk("R11 low nibble kept", 32'(nibs[b_nib]), 2);
        chk("R11 high nibble kept", 32'(nibs[b_nib+1]), 1);
        chk("R11 staged once", 32'(vcnt - b_vc), 1);
        chk("R11 data kept", vst_last, 32'h44 << (8 * PI));

        // Whole-run monitors
        chk("R6 no request while busy", 32'(viol), 0);
        chk("R7 access word shape", 32'(bad_word), 0);
        chk("R10 err only with done", 32'(ewd), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule